// File: doc/BRIEF.md
# Sixty-four source interrupt controller

This block gathers sixty-four active-low interrupt inputs into one request line for a processor. Each source has a pending bit and an enable (mask) bit. Both are kept as two 32-bit words, a high word and a low word. Source numbers do not map to bit positions arithmetically: a fixed scrambled placement, computed in a package, decides which word and which bit each source uses. Software reaches the state through a small register bus. Writes are strobed and take effect at the clock edge. Reads are combinational and reflect the addressed register straight away.

The sources fall into four classes. Internal sources always sense level-low. Seven external lines (sources 19 to 25) can sense level-low or falling edges. Sixteen port lines (sources 48 to 63) can sense both edges or falling edges only. Source 0 is reserved. An edge-select word picks the sense of the external and port lines. Edge-sensed pending bits are sticky and clear when software writes a 1 to them. Level-sensed pending bits mirror the input.

A vector register reports the lowest nonzero source number that is both pending and enabled. Software uses it to dispatch. The request output stays high while any such source exists. The register bus carries no streaming data, so it has no valid/ready handshake: a write completes in the cycle its strobe is high, and a read never stalls.

Top module: `intc64_top`

## Requirements
- R1: After reset, both mask words, both pending words and the edge-select word read 0, the vector reads 0 and `irq` is low.
- R2: A write to a mask word (address 0 high, 1 low) replaces the whole word and reads back unchanged. A mask bit of 1 enables its source.
- R3: For an edge-sensed source, writing 1 to its bit in a pending word (address 2 high, 3 low) clears it. Writing 0 leaves it unchanged.
- R4: For a level-sensed source, the pending bit equals the inverted input, one clock later. A clearing write has no effect while the input stays low.
- R5: Placement of sources in the words:
  - Sources 1..15 go to low bits 15..1. Source 0 goes to low bit 0.
  - Sources 16, 17 and 18 go to high bits 2, 1 and 0.
  - Sources 19..31 go to high bits 15..3.
  - Sources 32..47 go to high bits 31..16.
  - Sources 48..63 go to low bits 16..31.
- R6: External sources 19..25 use edge-select bit (33 − source) at address 4. A 1 in that bit selects sticky falling-edge sensing. A 0 selects level-low sensing.
- R7: Port sources 48..63 use edge-select bit (source − 32). A 1 in that bit selects falling edges only. A 0 selects both edges. Either way the pending bit is sticky.
- R8: Only edge-select bits 8..14 and 16..31 are stored; all other bits read 0. Internal sources sense level-low whatever the edge-select word holds.
- R9: The vector register (address 5) holds, in bits 31:26, the lowest nonzero source number that is pending and enabled, or 0 if there is none. Bits 25:0 read 0.
- R10: `irq` is high exactly when some pending source is also enabled. A masked source still shows in its pending word.
- R11: Source 0 never becomes pending.
- R12: When an edge arrives in the same cycle as a clearing write to the same source, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Interrupt inputs, active low, indexed by source number |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A register write, and any change on `src_n`, are registered at the next rising edge. Their effect on the pending words, the vector and `irq` is therefore visible from the following falling edge. The read data is combinational and is valid within the same cycle that the address is set. The bench therefore changes inputs only at a falling edge and lets one rising edge pass before it reads or compares, so every comparison lands exactly one cycle after its stimulus. The case where a clear and an edge meet is driven inside a single cycle on purpose, so that the set-over-clear ordering is seen at the next falling edge.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
  localparam int NSRC   = 64;
  localparam int WORD_W = 32;
  localparam int ID_W   = $clog2(NSRC);
  localparam int ADDR_W = 3;

  localparam int WORD_HI = 0;
  localparam int WORD_LO = 1;

  localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEND_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_ESEL    = 3'd4;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 3'd5;

  typedef enum logic [1:0] {
    CLS_RSVD = 2'd0,
    CLS_INT  = 2'd1,
    CLS_EXT  = 2'd2,
    CLS_PORT = 2'd3
  } src_class_e;

  function automatic src_class_e class_of(input int s);
    if (s == 0)                 return CLS_RSVD;
    else if (s >= 19 && s <= 25) return CLS_EXT;
    else if (s >= 48)           return CLS_PORT;
    else                        return CLS_INT;
  endfunction

  function automatic int word_of(input int s);
    return (s < 16 || s >= 48) ? WORD_LO : WORD_HI;
  endfunction

  function automatic int bit_of(input int s);
    if (s == 0)      return 0;
    else if (s < 16) return 16 - s;
    else if (s < 19) return 18 - s;
    else if (s < 32) return 34 - s;
    else if (s < 48) return 63 - s;
    else             return s - 32;
  endfunction

  function automatic int esel_bit_of(input int s);
    if (class_of(s) == CLS_EXT)       return 33 - s;
    else if (class_of(s) == CLS_PORT) return s - 32;
    else                              return 0;
  endfunction

  function automatic logic [WORD_W-1:0] esel_keep();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (class_of(s) == CLS_EXT || class_of(s) == CLS_PORT)
        m[esel_bit_of(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/intc64_sense.sv
module intc64_sense
  import intc64_pkg::*;
#(
  parameter src_class_e CLS = CLS_INT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_sel,
  input  logic clr,
  output logic pend
);
  generate
    if (CLS == CLS_RSVD) begin : g_rsvd
      assign pend = 1'b0;
    end else begin : g_live
      logic prev_q, pend_q, fall, rise, level_mode, hit;

      assign fall = prev_q & ~pin_n;
      assign rise = ~prev_q & pin_n;

      always_comb begin
        level_mode = 1'b0;
        hit        = 1'b0;
        case (CLS)
          CLS_EXT: begin
            level_mode = ~edge_sel;
            hit        = fall;
          end
          CLS_PORT: begin
            hit = edge_sel ? fall : (fall | rise);
          end
          default: level_mode = 1'b1;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          prev_q <= pin_n;
          if (level_mode) pend_q <= ~pin_n;
          else            pend_q <= hit | (pend_q & ~clr);
        end
      end

      assign pend = pend_q;
    end
  endgenerate
endmodule

// File: rtl/intc64_prio.sv
module intc64_prio
  import intc64_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]         req,
  output logic [$clog2(N)-1:0] id,
  output logic                 any
);
  localparam int IW = $clog2(N);

  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 1; i--)
      if (req[i]) id = IW'(i);
  end

  assign any = |req[N-1:1];
endmodule

// File: rtl/intc64_regs.sv
module intc64_regs
  import intc64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   pend_src,
  input  logic [ID_W-1:0]   vec_id,
  output logic [NSRC-1:0]   mask_src,
  output logic [NSRC-1:0]   esel_src,
  output logic [NSRC-1:0]   clr_src,
  output logic [WORD_W-1:0] esel_word,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam logic [WORD_W-1:0] ESEL_KEEP = esel_keep();

  logic [1:0][WORD_W-1:0] mask_q;
  logic [1:0][WORD_W-1:0] pend_w;
  logic [WORD_W-1:0]      esel_q;
  logic                   wr_pend_hi, wr_pend_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      esel_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MASK_HI) mask_q[WORD_HI] <= bus_wdata;
      if (bus_addr == A_MASK_LO) mask_q[WORD_LO] <= bus_wdata;
      if (bus_addr == A_ESEL)    esel_q <= bus_wdata & ESEL_KEEP;
    end
  end

  assign wr_pend_hi = bus_wr && (bus_addr == A_PEND_HI);
  assign wr_pend_lo = bus_wr && (bus_addr == A_PEND_LO);

  for (genvar s = 0; s < NSRC; s++) begin : g_map
    localparam int W = word_of(s);
    localparam int B = bit_of(s);
    localparam int E = esel_bit_of(s);
    assign mask_src[s] = mask_q[W][B];
    assign pend_w[W][B] = pend_src[s];
    assign clr_src[s]  = ((W == WORD_HI) ? wr_pend_hi : wr_pend_lo) & bus_wdata[B];
    if (class_of(s) == CLS_EXT || class_of(s) == CLS_PORT) begin : g_es
      assign esel_src[s] = esel_q[E];
    end else begin : g_nes
      assign esel_src[s] = 1'b0;
    end
  end

  assign esel_word = esel_q;

  always_comb begin
    case (bus_addr)
      A_MASK_HI: bus_rdata = mask_q[WORD_HI];
      A_MASK_LO: bus_rdata = mask_q[WORD_LO];
      A_PEND_HI: bus_rdata = pend_w[WORD_HI];
      A_PEND_LO: bus_rdata = pend_w[WORD_LO];
      A_ESEL:    bus_rdata = esel_q;
      A_VECTOR:  bus_rdata = {vec_id, {(WORD_W-ID_W){1'b0}}};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc64_top.sv
module intc64_top
  import intc64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NSRC-1:0]   pend_src, mask_src, esel_src, clr_src, req;
  logic [ID_W-1:0]   vec_id;
  logic [WORD_W-1:0] esel_word;

  intc64_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_src  (pend_src),
    .vec_id    (vec_id),
    .mask_src  (mask_src),
    .esel_src  (esel_src),
    .clr_src   (clr_src),
    .esel_word (esel_word),
    .bus_rdata (bus_rdata)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    intc64_sense #(.CLS(class_of(s))) u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (src_n[s]),
      .edge_sel (esel_src[s]),
      .clr      (clr_src[s]),
      .pend     (pend_src[s])
    );
  end

  assign req = pend_src & mask_src;

  intc64_prio #(.N(NSRC)) u_prio (
    .req (req),
    .id  (vec_id),
    .any (irq)
  );
endmodule

// File: rtl/intc64_checker.sv
module intc64_checker
  import intc64_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_n,
  input logic [NSRC-1:0]   pend_src,
  input logic [NSRC-1:0]   mask_src,
  input logic [NSRC-1:0]   clr_src,
  input logic [NSRC-1:0]   req,
  input logic [ID_W-1:0]   vec_id,
  input logic [WORD_W-1:0] esel_word,
  input logic              irq
);
  // R1: state is cleared in the cycle after reset is seen
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pend_src == '0 && mask_src == '0 && esel_word == '0));

  // R9 / R10: request line agrees with the encoder result
  assert_irq_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_id != '0));

  // R9: the reported source is requesting and no lower nonzero one is
  assert_vec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_id != '0) |->
      (req[vec_id] && ((req & ((64'd1 << vec_id) - 64'd1) & ~64'd1) == '0)));

  // R11: reserved source stays idle
  assert_src0_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_src[0]);

  // R4: an internal source mirrors its inverted input one cycle later
  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_src[1] == !$past(src_n[1])));

  // R7 / R3: port pending holds until a clearing write
  for (genvar p = 48; p < NSRC; p++) begin : g_port
    assert_port_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pend_src[p]) && !$past(clr_src[p])) |-> pend_src[p]);
  end
endmodule

bind intc64_top intc64_checker u_intc64_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_n     (src_n),
  .pend_src  (pend_src),
  .mask_src  (mask_src),
  .clr_src   (clr_src),
  .req       (req),
  .vec_id    (vec_id),
  .esel_word (esel_word),
  .irq       (irq)
);

// File: tb/intc64_top_tb_top.sv
module intc64_top_tb_top;
  import intc64_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [63:0] IDLE = '1;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_SRC = 2'd2, K_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  addr;
    logic [63:0] val;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 63;
  localparam step_t TBL [NSTEP] = '{
    '{K_RD,  3'd0, 64'h0, 4'd1},                     // R1 mask hi
    '{K_RD,  3'd3, 64'h0, 4'd1},                     // R1 pend lo
    '{K_RD,  3'd5, 64'h0, 4'd1},                     // R1 vector
    '{K_IRQ, 3'd0, 64'h0, 4'd1},                     // R1 irq
    '{K_WR,  3'd0, 64'hFFFFFFFF, 4'd2},              // R2
    '{K_WR,  3'd1, 64'hFFFFFFFF, 4'd2},              // R2
    '{K_RD,  3'd1, 64'hFFFFFFFF, 4'd2},              // R2 readback
    '{K_SRC, 3'd0, ~(64'd1 << 5), 4'd4},             // src 5 low
    '{K_RD,  3'd3, 64'h800, 4'd5},                   // R5 / R4 src5 -> lo bit 11
    '{K_RD,  3'd5, 64'h14000000, 4'd9},              // R9
    '{K_IRQ, 3'd0, 64'h1, 4'd10},                    // R10
    '{K_WR,  3'd3, 64'h800, 4'd4},                   // clear attempt
    '{K_RD,  3'd3, 64'h800, 4'd4},                   // R4 still pending
    '{K_SRC, 3'd0, IDLE, 4'd4},
    '{K_RD,  3'd3, 64'h0, 4'd4},                     // R4 follows input
    '{K_SRC, 3'd0, ~(64'd1 << 40), 4'd5},
    '{K_RD,  3'd2, 64'h00800000, 4'd5},              // R5 src40 -> hi bit 23
    '{K_SRC, 3'd0, ~(64'd1 << 17), 4'd5},
    '{K_RD,  3'd2, 64'h2, 4'd5},                     // R5 src17 -> hi bit 1
    '{K_RD,  3'd5, 64'h44000000, 4'd9},              // R9
    '{K_SRC, 3'd0, ~((64'd1 << 17) | (64'd1 << 3)), 4'd9},
    '{K_RD,  3'd5, 64'h0C000000, 4'd9},              // R9 lowest wins
    '{K_WR,  3'd1, 64'h0, 4'd10},
    '{K_RD,  3'd5, 64'h44000000, 4'd10},             // R10 masked skipped
    '{K_RD,  3'd3, 64'h2000, 4'd10},                 // R10 masked visible
    '{K_WR,  3'd0, 64'h0, 4'd10},
    '{K_IRQ, 3'd0, 64'h0, 4'd10},                    // R10 all masked
    '{K_SRC, 3'd0, IDLE, 4'd10},
    '{K_WR,  3'd0, 64'hFFFFFFFF, 4'd2},
    '{K_WR,  3'd1, 64'hFFFFFFFF, 4'd2},
    '{K_SRC, 3'd0, ~(64'd1 << 50), 4'd7},            // port falling, both mode
    '{K_RD,  3'd3, 64'h40000, 4'd7},                 // R7
    '{K_WR,  3'd3, 64'h40000, 4'd3},
    '{K_RD,  3'd3, 64'h0, 4'd3},                     // R3 cleared
    '{K_SRC, 3'd0, IDLE, 4'd7},                      // rising
    '{K_RD,  3'd3, 64'h40000, 4'd7},                 // R7 both edges
    '{K_WR,  3'd3, 64'h0, 4'd3},
    '{K_RD,  3'd3, 64'h40000, 4'd3},                 // R3 write 0 keeps
    '{K_WR,  3'd3, 64'h40000, 4'd3},
    '{K_WR,  3'd4, 64'h40000, 4'd7},
    '{K_RD,  3'd4, 64'h40000, 4'd7},                 // R7 esel readback
    '{K_SRC, 3'd0, ~(64'd1 << 50), 4'd7},
    '{K_RD,  3'd3, 64'h40000, 4'd7},                 // R7 falling seen
    '{K_WR,  3'd3, 64'h40000, 4'd3},
    '{K_SRC, 3'd0, IDLE, 4'd7},
    '{K_RD,  3'd3, 64'h0, 4'd7},                     // R7 rising ignored
    '{K_SRC, 3'd0, ~(64'd1 << 20), 4'd6},
    '{K_RD,  3'd2, 64'h4000, 4'd6},                  // R6 level mode
    '{K_SRC, 3'd0, IDLE, 4'd6},
    '{K_RD,  3'd2, 64'h0, 4'd6},                     // R6 level follows
    '{K_WR,  3'd4, 64'h2000, 4'd6},
    '{K_SRC, 3'd0, ~(64'd1 << 20), 4'd6},
    '{K_SRC, 3'd0, IDLE, 4'd6},
    '{K_RD,  3'd2, 64'h4000, 4'd6},                  // R6 sticky falling
    '{K_WR,  3'd2, 64'h4000, 4'd3},
    '{K_RD,  3'd2, 64'h0, 4'd3},                     // R3
    '{K_WR,  3'd4, 64'hFFFFFFFF, 4'd8},
    '{K_RD,  3'd4, 64'hFFFF7F00, 4'd8},              // R8 stored bits
    '{K_SRC, 3'd0, ~(64'd1 << 5), 4'd8},
    '{K_SRC, 3'd0, IDLE, 4'd8},
    '{K_RD,  3'd3, 64'h0, 4'd8},                     // R8 internal stays level
    '{K_SRC, 3'd0, ~64'd1, 4'd11},
    '{K_RD,  3'd5, 64'h0, 4'd11}                     // R11 src0 idle
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = IDLE;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc64_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_n     (src_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input int r, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = a;
    #1 check(r, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      case (TBL[i].kind)
        K_WR: begin
          bus_wr = 1'b1;
          bus_addr = TBL[i].addr;
          bus_wdata = TBL[i].val[31:0];
        end
        K_RD: begin
          bus_addr = TBL[i].addr;
          #1 check(int'(TBL[i].req), bus_rdata, TBL[i].val[31:0]);
        end
        K_SRC: src_n = TBL[i].val;
        default: #1 check(int'(TBL[i].req), {31'd0, irq}, TBL[i].val[31:0]);
      endcase
    end

    // R12: edge and clearing write in the same cycle, set wins
    @(negedge clk);
    src_n = ~(64'd1 << 50);
    bus_wr = 1'b1;
    bus_addr = A_PEND_LO;
    bus_wdata = 32'h40000;
    rd(12, A_PEND_LO, 32'h40000);
    rd(9, A_VECTOR, 32'hC8000000);   // R9 src 50 on vector
    #1 check(10, {31'd0, irq}, 32'd1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    src_n = IDLE;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(1, A_MASK_LO, 32'h0);
    rd(1, A_ESEL, 32'h0);
    rd(1, A_PEND_LO, 32'h0);
    #1 check(1, {31'd0, irq}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule